// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block picks where each execute-stage ALU operand of a five-stage in-order integer pipeline comes from. It compares the two source register numbers of the instruction now in execute with the destination register numbers of the two older instructions still in flight. These are the one in the memory stage and the one in write-back. For each operand it drives a 2-bit select that an external operand mux uses to take either the register-file value, the memory-stage ALU result, or the write-back value. A result therefore reaches the very next instruction one cycle after it is computed, without waiting for write-back.

The block also holds the integer register file, written by the write-back stage and read by the decode stage. When decode reads the same register that write-back is writing in that cycle, the register file passes the new value straight through. The instruction three places behind a producer therefore sees the fresh result. Register 0 is hard-wired to zero, and a write to it has no effect. The ALU, the memories and the pipeline registers sit outside this block.

Top module: `fwd_bypass_top`

## Requirements
- R1: When neither in-flight producer matches a source register, that operand's select is 2'b00 (register file).
- R2: When the memory-stage producer has its write flag set, its destination equals the operand's source and is not register 0, the select is 2'b10 (memory-stage result).
- R3: When only the write-back producer has its write flag set, a destination equal to the source and a destination other than register 0, the select is 2'b01 (write-back value).
- R4: When both producers qualify for the same operand, the memory-stage (newer) one wins and the select is 2'b10.
- R5: A producer whose destination is register 0 never causes forwarding.
- R6: A producer whose write flag is clear never causes forwarding, even when its destination matches.
- R7: The two operand selects are computed independently, each from its own source register (first source drives the A select, second source the B select).
- R8: A register-file write with the write flag set lands at the clock edge, and later reads of that register return the written data.
- R9: A decode-stage read of the register being written in the same cycle returns the data being written, not the stored value.
- R10: Register 0 always reads as zero, including in the cycle it is written and after the write.
- R11: A synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs1 | input | 5 | First source register of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source register of the execute-stage instruction |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Register-write flag of the memory-stage instruction |
| wb_rd | input | 5 | Destination register of the write-back instruction, also the register-file write address |
| wb_we | input | 1 | Register-write flag of the write-back instruction, also the register-file write enable |
| wb_data | input | 32 | Write-back value, written to the register file |
| id_ra1 | input | 5 | Decode-stage first read address |
| id_ra2 | input | 5 | Decode-stage second read address |
| id_rd1 | output | 32 | Decode-stage first read data |
| id_rd2 | output | 32 | Decode-stage second read data |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b | output | 2 | Operand B select: same encoding as fwd_a |

## Verification
The bench aims at the case where both producers match one operand. A design that lets the older value win would hand the consumer a stale result and return 01 where 10 is due. It drives matching destinations with the write flag clear, and matching destinations that are register 0. A design that forgets either qualifier would forward a value that was never produced. It runs one producer followed by four consumers through a reference pipeline model. That sequence covers memory-stage forwarding, write-back forwarding, the same-cycle register-file pass-through and the ordinary stored read in turn. A missing pass-through shows up as the third consumer reading the old zero.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    // A producer qualifies when it writes, targets a real register and matches
    function automatic logic producer_hit(input logic we, input logic [7:0] dst,
                                          input logic [7:0] src);
        return we && (dst != 8'd0) && (dst == src);
    endfunction

endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output fwd_sel_e      sel
);
    logic [7:0] src_w, mem_w, wb_w;
    logic       hit_mem, hit_wb;

    always_comb begin
        src_w = 8'(src);
        mem_w = 8'(mem_dst);
        wb_w  = 8'(wb_dst);
        hit_mem = producer_hit(mem_wr, mem_w, src_w);
        hit_wb  = producer_hit(wb_wr, wb_w, src_w);
        if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    always_comb begin
        // R5
        if (src == '0) zero_src_chk: assert (sel == SEL_RF);
        // R6
        if (!mem_wr && !wb_wr) no_writer_chk: assert (sel == SEL_RF);
        // R4
        if (mem_wr && wb_wr && src != '0 && mem_dst == src && wb_dst == src)
            newest_wins_chk: assert (sel == SEL_MEM);
    end

endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             wa,
    input  logic [XLEN-1:0]           wd,
    input  logic [NRD-1:0][AW-1:0]    ra,
    output logic [NRD-1:0][XLEN-1:0]  rd
);
    logic [XLEN-1:0] regs [NREGS];
    logic            past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
            past_ok <= 1'b0;
        end else begin
            if (we && wa != '0) regs[wa] <= wd;
            past_ok <= 1'b1;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        always_comb begin
            if (ra[p] == '0)                 rd[p] = '0;
            else if (we && wa == ra[p])      rd[p] = wd;
            else                             rd[p] = regs[ra[p]];
        end

        // R9
        same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            (we && wa != '0 && wa == ra[p]) |-> rd[p] == wd);
        // R10
        zero_read_chk: assert property (@(posedge clk) disable iff (rst)
            (ra[p] == '0) |-> rd[p] == '0);
        // R8
        stored_read_chk: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(we) && $past(wa) != '0 && ra[p] == $past(wa)
             && !(we && wa == ra[p])) |-> rd[p] == $past(wd));
    end

endmodule

// File: rtl/fwd_bypass_top.sv
module fwd_bypass_top
    import fwd_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ex_rs1,
    input  logic [AW-1:0]   ex_rs2,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_we,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_we,
    input  logic [XLEN-1:0] wb_data,
    input  logic [AW-1:0]   id_ra1,
    input  logic [AW-1:0]   id_ra2,
    output logic [XLEN-1:0] id_rd1,
    output logic [XLEN-1:0] id_rd2,
    output logic [1:0]      fwd_a,
    output logic [1:0]      fwd_b
);
    localparam int NOPS = 2;

    logic [NOPS-1:0][AW-1:0]   src_vec;
    fwd_sel_e                  sel_vec [NOPS];
    logic [NOPS-1:0][AW-1:0]   raddr;
    logic [NOPS-1:0][XLEN-1:0] rdata;

    assign src_vec = {ex_rs2, ex_rs1};
    assign raddr   = {id_ra2, id_ra1};

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        fwd_pick #(.AW(AW)) u_pick (
            .src     (src_vec[k]),
            .mem_dst (mem_rd),
            .mem_wr  (mem_we),
            .wb_dst  (wb_rd),
            .wb_wr   (wb_we),
            .sel     (sel_vec[k])
        );
    end

    assign fwd_a = sel_vec[0];
    assign fwd_b = sel_vec[1];

    rf_bypass #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NOPS)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (wb_we),
        .wa  (wb_rd),
        .wd  (wb_data),
        .ra  (raddr),
        .rd  (rdata)
    );

    assign id_rd1 = rdata[0];
    assign id_rd2 = rdata[1];

    // R7
    op_b_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 != ex_rs2 && mem_we && mem_rd == ex_rs1 && mem_rd != '0
         && !(wb_we && wb_rd == ex_rs2)) |-> fwd_b == 2'b00);

endmodule

// File: tb/fwd_bypass_top_tb.sv
`timescale 1ns/1ps
module fwd_bypass_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  ex_rs1, ex_rs2, mem_rd, wb_rd, id_ra1, id_ra2;
    logic        mem_we, wb_we;
    logic [31:0] wb_data, id_rd1, id_rd2;
    logic [1:0]  fwd_a, fwd_b;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] ref_rf [32];

    always #2.5 clk = ~clk;

    fwd_bypass_top u_dut (
        .clk(clk), .rst(rst), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .wb_data(wb_data), .id_ra1(id_ra1), .id_ra2(id_ra2),
        .id_rd1(id_rd1), .id_rd2(id_rd2), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // fields: rs1, rs2, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b
    localparam int NV = 10;
    localparam logic [25:0] VEC [NV] = '{
        {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1
        {5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b10, 2'b00}, // R2
        {5'd1,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b01}, // R3 R7
        {5'd6,  5'd6,  5'd6,  1'b1, 5'd6,  1'b1, 2'b10, 2'b10}, // R4
        {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
        {5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00}, // R6
        {5'd9,  5'd1,  5'd9,  1'b0, 5'd9,  1'b1, 2'b01, 2'b00}, // R6 R3
        {5'd2,  5'd8,  5'd8,  1'b1, 5'd2,  1'b1, 2'b01, 2'b10}, // R7
        {5'd31, 5'd5,  5'd31, 1'b1, 5'd31, 1'b1, 2'b10, 2'b00}, // R4
        {5'd12, 5'd0,  5'd0,  1'b1, 5'd12, 1'b1, 2'b01, 2'b00}  // R5 R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic [4:0] md,
                                           input logic mw, input logic [4:0] wd,
                                           input logic ww);
        if (s != 0 && mw && md == s) return 2'b10;
        if (s != 0 && ww && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic idle();
        ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_we = 0;
        wb_rd = 0; wb_we = 0; wb_data = 0; id_ra1 = 0; id_ra2 = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) ref_rf[i] = 0;
    endtask

    // producer I0 writes r5; I1..I4 consume it
    localparam int NI = 5;
    localparam logic [4:0] I_DST [NI] = '{5'd5, 5'd10, 5'd11, 5'd12, 5'd13};
    localparam logic [4:0] I_S1  [NI] = '{5'd1, 5'd5,  5'd2,  5'd5,  5'd5};
    localparam logic [4:0] I_S2  [NI] = '{5'd2, 5'd1,  5'd5,  5'd5,  5'd3};

    initial begin
        idle();
        rst = 1'b1;
        do_reset();

        // R11: all registers read zero after reset
        @(negedge clk);
        for (int r = 1; r < 32; r += 2) begin
            id_ra1 = 5'(r); id_ra2 = 5'(r - 1);
            #0.5;
            chk("R11 rd1", id_rd1, 32'h0);
            chk("R11 rd2", id_rd2, 32'h0);
        end
        chk("R1 reset sel", {30'h0, fwd_a}, 32'h0);

        // table of forwarding selects
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {ex_rs1, ex_rs2, mem_rd, mem_we, wb_rd, wb_we} = VEC[v][25:4];
            wb_we = 1'b0; // keep the register file untouched while walking
            if (VEC[v][4]) begin
                wb_we = 1'b1; wb_data = 32'h0; wb_rd = VEC[v][9:5];
            end
            #1;
            chk($sformatf("vec%0d sel A", v), {30'h0, fwd_a}, {30'h0, VEC[v][3:2]});
            chk($sformatf("vec%0d sel B", v), {30'h0, fwd_b}, {30'h0, VEC[v][1:0]});
        end
        @(negedge clk);
        idle();
        do_reset();

        // R9 same-cycle pass-through and R8 stored read
        @(negedge clk);
        wb_we = 1; wb_rd = 7; wb_data = 32'h1234_5677; id_ra1 = 7; id_ra2 = 8;
        #1;
        chk("R9 same-cycle read", id_rd1, 32'h1234_5677);
        chk("R8 other reg untouched", id_rd2, 32'h0);
        @(negedge clk);
        wb_we = 0; wb_data = 32'hDEAD_BEEF;
        #1;
        chk("R8 stored read", id_rd1, 32'h1234_5677);
        chk("R8 idle write ignored", id_rd2, 32'h0);

        // R10 register 0
        @(negedge clk);
        wb_we = 1; wb_rd = 0; wb_data = 32'hFFFF_FFFF; id_ra1 = 0;
        #1;
        chk("R10 zero same cycle", id_rd1, 32'h0);
        @(negedge clk);
        wb_we = 0;
        #1;
        chk("R10 zero after write", id_rd1, 32'h0);

        // R6 write flag clear: no write lands
        @(negedge clk);
        wb_we = 0; wb_rd = 9; wb_data = 32'h5555_0000; id_ra1 = 9;
        @(negedge clk);
        #1;
        chk("R6 disabled write", id_rd1, 32'h0);

        // R11 reset clears a written register
        idle();
        do_reset();
        @(negedge clk);
        id_ra1 = 7;
        #1;
        chk("R11 cleared r7", id_rd1, 32'h0);

        // producer followed by four consumers, against a pipeline model
        // R2 (I1), R3 (I2), R9 (I3 decode), R8 (I4 decode)
        for (int t = -1; t <= NI + 1; t++) begin
            @(negedge clk);
            idle();
            if (t >= 0 && t < NI) begin
                ex_rs1 = I_S1[t]; ex_rs2 = I_S2[t];
            end
            if (t - 1 >= 0 && t - 1 < NI) begin
                mem_rd = I_DST[t-1]; mem_we = 1;
            end
            if (t - 2 >= 0 && t - 2 < NI) begin
                wb_rd = I_DST[t-2]; wb_we = 1; wb_data = 32'hCAFE_0000 + 32'(t - 2);
            end
            if (t + 1 >= 0 && t + 1 < NI) begin
                id_ra1 = I_S1[t+1]; id_ra2 = I_S2[t+1];
            end
            #1;
            chk($sformatf("seq t%0d R2/R3 A", t), {30'h0, fwd_a},
                {30'h0, ref_sel(ex_rs1, mem_rd, mem_we, wb_rd, wb_we)});
            chk($sformatf("seq t%0d R2/R3 B", t), {30'h0, fwd_b},
                {30'h0, ref_sel(ex_rs2, mem_rd, mem_we, wb_rd, wb_we)});
            chk($sformatf("seq t%0d R9/R8 rd1", t), id_rd1,
                (id_ra1 == 0) ? 32'h0 :
                (wb_we && wb_rd == id_ra1) ? wb_data : ref_rf[id_ra1]);
            chk($sformatf("seq t%0d R9/R8 rd2", t), id_rd2,
                (id_ra2 == 0) ? 32'h0 :
                (wb_we && wb_rd == id_ra2) ? wb_data : ref_rf[id_ra2]);
            if (wb_we && wb_rd != 0) ref_rf[wb_rd] = wb_data;
        end

        @(negedge clk);
        idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule